// File: doc/BRIEF.md
# Complementary PWM Deadband Generator

This block turns one reference PWM waveform per channel into a complementary pair of gate drive signals: a main output that follows the reference and a complementary output that follows its inverse. Each output turns on only after a programmable dead time, counted in clock cycles. Each output turns off without that delay. Because of this, the two switches of a half bridge are never driven on at the same time. A reference interval that is not longer than the dead time gives no pulse at all on the matching output.

Each channel has its own dead-time count. Each output has its own polarity bit and enable bit. A global drive-enable decides whether the pins carry the deadband result or per-output idle levels. The timer that produces the reference and any fault or break logic sit outside the block. All outputs are registered. A change on the reference reaches the pins two clock edges after it is sampled. A change on any control input reaches the pins one edge after it is sampled.

Top module: `cdb_deadband`

## Requirements
- R1: While rst_ni is low, every main_o and comp_o bit is 0. After reset, each channel behaves as if its reference had been sampled low once.
- R2: With both outputs of a channel enabled and polarity 0, main_o is 1 in the cycle after edge k+1 exactly when ref_i was sampled 1 at edges k-D through k, where D is that channel's dead_time_i.
- R3: Under the same conditions, comp_o is 1 in the cycle after edge k+1 exactly when ref_i was sampled 0 at edges k-D through k.
- R4: Turn-off is not delayed. If ref_i is sampled low at edge k, main_o is inactive after edge k+1. If ref_i is sampled high at edge k, comp_o is inactive after edge k+1.
- R5: A high or low reference interval of L samples gives an output pulse of max(0, L-D) cycles. An interval with L at or below D is swallowed completely.
- R6: With D = 0 and both outputs enabled, the active level of main_o equals ref_i two edges earlier, and comp_o is its exact complement.
- R7: A polarity bit of 1 inverts that pin. The pin equals the active state XOR the polarity bit, so the inactive level of a pin equals its polarity bit.
- R8: With drive enabled, an output whose enable bit is 0 drives its inactive level. The other output of that channel then follows the reference (or its inverse) with no dead time.
- R9: When moe_i is low, each pin drives its own idle_main_i or idle_comp_i bit, one edge after sampling.
- R10: While moe_i is high and both outputs of a channel are enabled, main_o and comp_o of that channel are never active together.
- R11: Channels are independent. Each channel uses its own reference, dead time, polarity, enable and idle bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | N_CH | Reference PWM, one bit per channel |
| dead_time_i | input | N_CH x DT_W | Dead time in clock cycles, per channel |
| pol_main_i | input | N_CH | Main output polarity, 1 = active low |
| pol_comp_i | input | N_CH | Complementary output polarity, 1 = active low |
| en_main_i | input | N_CH | Main output enable |
| en_comp_i | input | N_CH | Complementary output enable |
| moe_i | input | 1 | Drive enable for all channels, 0 selects idle levels |
| idle_main_i | input | N_CH | Main pin level while drive is off |
| idle_comp_i | input | N_CH | Complementary pin level while drive is off |
| main_o | output | N_CH | Main gate output |
| comp_o | output | N_CH | Complementary gate output |

## Verification
A reference sample taken at edge k shows on the pins after edge k+1: one register holds the sampled level and run length, and a second register holds the pin value. Control inputs take effect after only one edge. The bench samples outputs at the falling edge. It keeps a history of every reference value it drove, indexed by edge number. It predicts each pin from the run length ending one edge back, together with the control values sampled at the edge just passed. Dead time, run lengths and all control bits are swept, so the turn-on delay, swallowed pulses and immediate turn-off are all compared cycle by cycle at that fixed offset.

// File: rtl/cdb_pkg.sv
`timescale 1ns/1ps
package cdb_pkg;
  typedef struct packed {
    logic pol;
    logic en;
    logic idle;
  } pin_cfg_t;

  // pin level from active-high raw state, pin config and drive enable
  function automatic logic pin_level(logic raw, pin_cfg_t cfg, logic moe);
    if (!moe)        return cfg.idle;
    else if (!cfg.en) return cfg.pol;
    else             return raw ^ cfg.pol;
  endfunction
endpackage

// File: rtl/cdb_run_timer.sv
`timescale 1ns/1ps
module cdb_run_timer #(
  parameter int DT_W = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ref_i,
  output logic            ref_q_o,
  output logic [DT_W-1:0] run_o
);
  localparam logic [DT_W-1:0] RUN_MAX = '1;

  logic            ref_q;
  logic [DT_W-1:0] run_q;

  // run_q = samples since the last level change, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= 1'b0;
      run_q <= '0;
    end else if (ref_i != ref_q) begin
      ref_q <= ref_i;
      run_q <= '0;
    end else if (run_q != RUN_MAX) begin
      run_q <= run_q + 1'b1;
    end
  end

  assign ref_q_o = ref_q;
  assign run_o   = run_q;
endmodule

// File: rtl/cdb_dead_gate.sv
`timescale 1ns/1ps
module cdb_dead_gate #(
  parameter int DT_W = 10
) (
  input  logic            ref_q_i,
  input  logic [DT_W-1:0] run_i,
  input  logic [DT_W-1:0] dead_time_i,
  input  logic            insert_i,
  output logic            main_raw_o,
  output logic            comp_raw_o
);
  logic settled;

  // level held for more than dead_time samples, or no insertion
  assign settled    = (run_i >= dead_time_i) | ~insert_i;
  assign main_raw_o =  ref_q_i & settled;
  assign comp_raw_o = ~ref_q_i & settled;
endmodule

// File: rtl/cdb_out_stage.sv
`timescale 1ns/1ps
module cdb_out_stage
  import cdb_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     raw_i,
  input  pin_cfg_t cfg_i,
  input  logic     moe_i,
  output logic     pin_o
);
  logic pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else         pin_q <= pin_level(raw_i, cfg_i, moe_i);
  end

  assign pin_o = pin_q;
endmodule

// File: rtl/cdb_deadband.sv
`timescale 1ns/1ps
module cdb_deadband
  import cdb_pkg::*;
#(
  parameter int N_CH = 2,
  parameter int DT_W = 10
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_CH-1:0]            ref_i,
  input  logic [N_CH-1:0][DT_W-1:0]  dead_time_i,
  input  logic [N_CH-1:0]            pol_main_i,
  input  logic [N_CH-1:0]            pol_comp_i,
  input  logic [N_CH-1:0]            en_main_i,
  input  logic [N_CH-1:0]            en_comp_i,
  input  logic                       moe_i,
  input  logic [N_CH-1:0]            idle_main_i,
  input  logic [N_CH-1:0]            idle_comp_i,
  output logic [N_CH-1:0]            main_o,
  output logic [N_CH-1:0]            comp_o
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic            ref_q;
    logic [DT_W-1:0] run;
    logic            main_raw, comp_raw;
    pin_cfg_t        cfg_main, cfg_comp;

    assign cfg_main = '{pol: pol_main_i[c], en: en_main_i[c], idle: idle_main_i[c]};
    assign cfg_comp = '{pol: pol_comp_i[c], en: en_comp_i[c], idle: idle_comp_i[c]};

    cdb_run_timer #(.DT_W(DT_W)) u_timer (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ref_i  (ref_i[c]),
      .ref_q_o(ref_q),
      .run_o  (run)
    );

    cdb_dead_gate #(.DT_W(DT_W)) u_gate (
      .ref_q_i    (ref_q),
      .run_i      (run),
      .dead_time_i(dead_time_i[c]),
      .insert_i   (en_main_i[c] & en_comp_i[c]),
      .main_raw_o (main_raw),
      .comp_raw_o (comp_raw)
    );

    cdb_out_stage u_main (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (main_raw),
      .cfg_i (cfg_main),
      .moe_i (moe_i),
      .pin_o (main_o[c])
    );

    cdb_out_stage u_comp (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (comp_raw),
      .cfg_i (cfg_comp),
      .moe_i (moe_i),
      .pin_o (comp_o[c])
    );
  end
endmodule

module cdb_deadband_chk #(
  parameter int N_CH = 2,
  parameter int DT_W = 10
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [N_CH-1:0]           ref_i,
  input logic [N_CH-1:0][DT_W-1:0] dead_time_i,
  input logic [N_CH-1:0]           pol_main_i,
  input logic [N_CH-1:0]           pol_comp_i,
  input logic [N_CH-1:0]           en_main_i,
  input logic [N_CH-1:0]           en_comp_i,
  input logic                      moe_i,
  input logic [N_CH-1:0]           idle_main_i,
  input logic [N_CH-1:0]           idle_comp_i,
  input logic [N_CH-1:0]           main_o,
  input logic [N_CH-1:0]           comp_o
);
  // edges seen since reset, saturating at 2
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= 2'd0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  AST_RESET_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (main_o == '0) && (comp_o == '0)); // R1

  for (genvar c = 0; c < N_CH; c++) begin : g_chk
    AST_NO_DUAL_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age_q != 2'd0) && $past(moe_i && en_main_i[c] && en_comp_i[c])
      |-> !((main_o[c] ^ $past(pol_main_i[c])) && (comp_o[c] ^ $past(pol_comp_i[c])))); // R10

    AST_IDLE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age_q != 2'd0) && !$past(moe_i)
      |-> (main_o[c] == $past(idle_main_i[c])) && (comp_o[c] == $past(idle_comp_i[c]))); // R9

    AST_MAIN_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age_q != 2'd0) && $past(moe_i && !en_main_i[c])
      |-> main_o[c] == $past(pol_main_i[c])); // R8

    AST_COMP_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age_q != 2'd0) && $past(moe_i && !en_comp_i[c])
      |-> comp_o[c] == $past(pol_comp_i[c])); // R8

    AST_MAIN_OFF_NOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age_q == 2'd2) && $past(moe_i && en_main_i[c]) && !$past(ref_i[c], 2)
      |-> main_o[c] == $past(pol_main_i[c])); // R4

    AST_COMP_OFF_NOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age_q == 2'd2) && $past(moe_i && en_comp_i[c]) && $past(ref_i[c], 2)
      |-> comp_o[c] == $past(pol_comp_i[c])); // R4

    AST_ZERO_DEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age_q == 2'd2) && $past(moe_i && en_main_i[c] && en_comp_i[c] && (dead_time_i[c] == '0))
      |-> ((main_o[c] ^ $past(pol_main_i[c])) == $past(ref_i[c], 2))
          && ((comp_o[c] ^ $past(pol_comp_i[c])) != $past(ref_i[c], 2))); // R6
  end
endmodule

bind cdb_deadband cdb_deadband_chk #(.N_CH(N_CH), .DT_W(DT_W)) u_chk (.*);

// File: tb/tb_cdb_deadband.sv
`timescale 1ns/1ps
module tb_cdb_deadband;
  localparam int N_CH = 2;
  localparam int DT_W = 10;
  localparam int HMAX = 32768;

  logic                      clk_i = 1'b0;
  logic                      rst_ni = 1'b0;
  logic [N_CH-1:0]           ref_i = '0;
  logic [N_CH-1:0][DT_W-1:0] dead_time_i = '0;
  logic [N_CH-1:0]           pol_main_i = '0, pol_comp_i = '0;
  logic [N_CH-1:0]           en_main_i = '1, en_comp_i = '1;
  logic                      moe_i = 1'b1;
  logic [N_CH-1:0]           idle_main_i = '0, idle_comp_i = '0;
  logic [N_CH-1:0]           main_o, comp_o;

  cdb_deadband #(.N_CH(N_CH), .DT_W(DT_W)) dut (.*);

  always #4 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  int m = 0;
  bit hist [0:N_CH-1][0:HMAX-1];
  logic [7:0] lf = 8'h5a;

  task automatic check(string tag, int c, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s ch%0d %s edge %0d: actual %b expected %b", tag, c, what, m, act, exp);
    end
  endtask

  function automatic int run_len(int c, int idx);
    int r = 1;
    for (int j = idx; j > 0 && hist[c][j-1] == hist[c][idx]; j--) r++;
    return r;
  endfunction

  // expected pin after edge m: reference history up to edge m-1, controls sampled at edge m
  function automatic logic exp_pin(int c, bit comp, output string tag);
    int   idx  = m - 1;
    bit   last = hist[c][idx];
    int   r    = run_len(c, idx);
    bit   ins  = en_main_i[c] & en_comp_i[c];
    bit   lvl  = comp ? !last : last;
    int   d    = int'(dead_time_i[c]);
    bit   pol  = comp ? pol_comp_i[c] : pol_main_i[c];
    bit   en   = comp ? en_comp_i[c] : en_main_i[c];
    bit   idl  = comp ? idle_comp_i[c] : idle_main_i[c];
    bit   raw  = lvl && (!ins || r > d);
    string b;
    if (!moe_i)      b = "R9";
    else if (!ins)   b = "R8";
    else if (pol)    b = "R7";
    else if (d == 0) b = "R6";
    else if (!lvl)   b = "R4";
    else if (r <= d) b = "R5";
    else             b = comp ? "R3" : "R2";
    tag = (c == 1) ? {"R11/", b} : b;
    if (!moe_i) return idl;
    if (!en)    return pol;
    return raw ^ pol;
  endfunction

  task automatic check_all();
    for (int c = 0; c < N_CH; c++) begin
      string t;
      logic e;
      e = exp_pin(c, 1'b0, t);
      check(t, c, "main_o", main_o[c], e);
      e = exp_pin(c, 1'b1, t);
      check(t, c, "comp_o", comp_o[c], e);
      if (moe_i && en_main_i[c] && en_comp_i[c])
        check("R10", c, "both active", (main_o[c] ^ pol_main_i[c]) & (comp_o[c] ^ pol_comp_i[c]), 1'b0);
    end
  endtask

  task automatic step(bit r0);
    @(negedge clk_i);
    m++;
    check_all();
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    ref_i[0] = r0;
    ref_i[1] = lf[0];
    hist[0][m+1] = r0;
    hist[1][m+1] = lf[0];
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired at edge %0d", m);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int wset [6] = '{1, 4, 2, 7, 3, 5};
    repeat (3) begin
      @(negedge clk_i);
      for (int c = 0; c < N_CH; c++) begin
        check("R1", c, "main_o in reset", main_o[c], 1'b0);
        check("R1", c, "comp_o in reset", comp_o[c], 1'b0);
      end
    end
    rst_ni = 1'b1;
    m = 0;
    for (int c = 0; c < N_CH; c++) begin
      hist[c][0] = 1'b0;
      hist[c][1] = 1'b0;
    end

    // dead time sweep over every high/low width pair (R2, R3, R4, R5, R11)
    for (int d = 0; d <= 6; d++) begin
      dead_time_i[0] = DT_W'(d);
      dead_time_i[1] = DT_W'(d % 3);
      for (int wh = 1; wh <= 7; wh++)
        for (int wl = 1; wl <= 7; wl++) begin
          repeat (wh) step(1'b1);
          repeat (wl) step(1'b0);
        end
    end

    // control sweep: polarity, enables, drive enable, dead time (R6, R7, R8, R9)
    for (int cfg = 0; cfg < 128; cfg++) begin
      int dsel [4] = '{0, 1, 3, 6};
      pol_main_i  = {~cfg[0], cfg[0]};
      pol_comp_i  = {cfg[0] ^ cfg[1], cfg[1]};
      en_main_i   = {cfg[3], cfg[2]};
      en_comp_i   = {cfg[2], cfg[3]};
      moe_i       = cfg[4];
      idle_main_i = {cfg[1], cfg[0] ^ cfg[6]};
      idle_comp_i = {~cfg[1], ~(cfg[0] ^ cfg[6])};
      dead_time_i[0] = DT_W'(dsel[cfg[6:5]]);
      dead_time_i[1] = DT_W'(dsel[3 - cfg[6:5]]);
      for (int i = 0; i < 6; i++) begin
        repeat (wset[i]) step(1'b1);
        repeat (wset[5-i]) step(1'b0);
      end
    end

    step(1'b0);
    step(1'b0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule